// File: doc/BRIEF.md
# Memory Controller Bank Configuration Registers

This block is the configuration register file of a four-bank memory controller. Software reaches every register indirectly. It first writes an internal 8-bit offset to the address port, then reads or writes the data port, which acts on the register at that offset. The file holds several kinds of registers:

- per-bank mapping registers, each packing a base, a size code and an enable bit;
- a global configuration register with a status register that tracks its enable bits;
- refresh, timing, power-management and ECC configuration registers;
- an error address register;
- two write-one-to-clear error status registers.

Alongside the registers, the block decodes a physical address against the mapped banks. It returns a hit flag and the index of the winning bank. It also drives an ECC error interrupt from the ECC error status register. The error status registers collect error bits that the memory sequencer posts through two set inputs.

Top module: `mcfg_top`

## Requirements
- R1: Writing with `bus_sel`=0 stores `bus_wdata[7:0]` as the current offset, and reading with `bus_sel`=0 returns that offset zero-extended. With `bus_sel`=1 the data port reads or writes the register at the current offset, and reads are combinational. The error address register at offset 0x10 stores full 32-bit writes.
- R2: After reset the registers hold these values: 0x07C00000 at 0x34, 0x05F00000 at 0x30, 0x00854009 at 0x80, 0x00800000 at 0x20, and zero everywhere else. At the same point `bank_hit`=0 and `ecc_irq`=0.
- R3: Config (0x20) stores full writes. When config bit 31 goes from 0 to 1, status (0x24) bit 31 is cleared. When config bit 31 goes from 1 to 0, status bit 31 is set.
- R4: Status bit 30 is set when config bit 30 goes from 0 to 1 and cleared when it goes from 1 to 0. Writes to status (0x24) have no effect.
- R5: For the error status registers at 0x00 and 0x08, a data write clears the bits written as 1. In each cycle, bits on `err0_set`/`err1_set` are ORed in, and a set wins over a clear of the same bit in the same cycle.
- R6: Writes are masked as follows: refresh (0x30) with 0x3FF80000, timing (0x80) with 0x018FC01F, and ECC config (0x94) with 0x00F00000. A power-management write (0x34) stores (value AND 0xF8000000) OR 0x07C00000.
- R7: Bank registers sit at 0x40, 0x44, 0x48 and 0x4C for banks 0 to 3, and writes to them are masked with 0xFFDEE001. Bits 31:23 are the base address bits 31:23, bits 19:17 are the size code, and bit 0 is the bank enable.
- R8: A bank matches an address only when all of these hold: config bit 31 is 1, the bank's enable bit is 1, its size code is below 7, and base ≤ address < base + (4 MiB << code).
- R9: When several banks match, the lowest-numbered bank wins. `bank_idx` is 0 when nothing matches.
- R10: `ecc_irq` rises in the cycle after a write that moves ECC error status (0x98, full write) from zero to nonzero. It falls in the cycle after a write that moves it from nonzero to zero.
- R11: Offsets not listed above read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | 0 selects the address port, 1 selects the data port |
| bus_wr | input | 1 | Write strobe for the selected port |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected port |
| err0_set | input | 32 | Error bits to post into error status 0 |
| err1_set | input | 32 | Error bits to post into error status 1 |
| phys_addr | input | 32 | Physical address to decode |
| bank_hit | output | 1 | Address falls in an enabled bank |
| bank_idx | output | 2 | Index of the winning bank |
| ecc_irq | output | 1 | ECC error interrupt |

## Verification
A corrupted bank field or enable flag does not show up on any read. It first appears on `bank_hit`/`bank_idx` for an address near that bank's edge, and it appears in the same cycle, because decoding is combinational from the stored registers. A wrong status or interrupt flop shows at the ports one cycle after the config or ECC write that should have moved it. For that reason the bench reads back each register right after writing it and probes decode addresses that straddle bank bounds.

// File: rtl/mcfg_pkg.sv
package mcfg_pkg;
    localparam int DW        = 32;
    localparam int OFF_W     = 8;
    localparam int NUM_BANKS = 4;
    localparam int IDX_W     = $clog2(NUM_BANKS);

    localparam logic [OFF_W-1:0] OFF_ERR0  = 8'h00;
    localparam logic [OFF_W-1:0] OFF_ERR1  = 8'h08;
    localparam logic [OFF_W-1:0] OFF_EADDR = 8'h10;
    localparam logic [OFF_W-1:0] OFF_CFG   = 8'h20;
    localparam logic [OFF_W-1:0] OFF_STAT  = 8'h24;
    localparam logic [OFF_W-1:0] OFF_RFSH  = 8'h30;
    localparam logic [OFF_W-1:0] OFF_PWR   = 8'h34;
    localparam logic [OFF_W-1:0] OFF_BANK0 = 8'h40;
    localparam logic [OFF_W-1:0] OFF_TIM   = 8'h80;
    localparam logic [OFF_W-1:0] OFF_ECFG  = 8'h94;
    localparam logic [OFF_W-1:0] OFF_ESTAT = 8'h98;

    localparam logic [DW-1:0] MSK_BANK = 32'hFFDE_E001;
    localparam logic [DW-1:0] MSK_RFSH = 32'h3FF8_0000;
    localparam logic [DW-1:0] MSK_TIM  = 32'h018F_C01F;
    localparam logic [DW-1:0] MSK_ECFG = 32'h00F0_0000;
    localparam logic [DW-1:0] MSK_PWR  = 32'hF800_0000;
    localparam logic [DW-1:0] FIX_PWR  = 32'h07C0_0000;

    localparam logic [DW-1:0] RST_PWR  = 32'h07C0_0000;
    localparam logic [DW-1:0] RST_RFSH = 32'h05F0_0000;
    localparam logic [DW-1:0] RST_TIM  = 32'h0085_4009;
    localparam logic [DW-1:0] RST_CFG  = 32'h0080_0000;

    localparam int DEC_EN_BIT = 31;
    localparam int AUX_BIT    = 30;
    localparam logic [DW:0] UNIT_SIZE = 33'h0_0040_0000;

    typedef struct packed {
        logic       en;
        logic [8:0] base;
        logic [2:0] code;
    } bank_map_t;

    typedef enum logic [1:0] {ACC_NONE, ACC_ADDR, ACC_DATA} acc_t;

    function automatic bank_map_t unpack_bank(input logic [DW-1:0] r);
        bank_map_t m;
        m.en   = r[0];
        m.base = r[31:23];
        m.code = r[19:17];
        return m;
    endfunction

    function automatic logic [OFF_W-1:0] bank_off(input int i);
        return OFF_BANK0 + OFF_W'(4 * i);
    endfunction
endpackage

// File: rtl/mcfg_regfile.sv
module mcfg_regfile
    import mcfg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [DW-1:0]         bus_wdata,
    output logic [DW-1:0]         bus_rdata,
    input  logic [DW-1:0]         err0_set,
    input  logic [DW-1:0]         err1_set,
    output logic                  dec_en,
    output bank_map_t             maps [NUM_BANKS],
    output logic                  ecc_irq
);
    logic [OFF_W-1:0] off_q;
    logic [DW-1:0] err0_q, err1_q, eaddr_q, cfg_q, stat_q, rfsh_q, pwr_q;
    logic [DW-1:0] tim_q, ecfg_q, estat_q;
    logic [DW-1:0] bank_q [NUM_BANKS];
    logic          irq_q;
    acc_t          acc;
    logic          dwr;

    always_comb begin
        if (!bus_wr)      acc = ACC_NONE;
        else if (bus_sel) acc = ACC_DATA;
        else              acc = ACC_ADDR;
    end
    assign dwr = (acc == ACC_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q   <= '0;
            err0_q  <= '0;
            err1_q  <= '0;
            eaddr_q <= '0;
            cfg_q   <= RST_CFG;
            stat_q  <= '0;
            rfsh_q  <= RST_RFSH;
            pwr_q   <= RST_PWR;
            tim_q   <= RST_TIM;
            ecfg_q  <= '0;
            estat_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            if (acc == ACC_ADDR) off_q <= bus_wdata[OFF_W-1:0];
            err0_q <= ((dwr && off_q == OFF_ERR0) ? (err0_q & ~bus_wdata) : err0_q) | err0_set;
            err1_q <= ((dwr && off_q == OFF_ERR1) ? (err1_q & ~bus_wdata) : err1_q) | err1_set;
            if (dwr) begin
                case (off_q)
                    OFF_EADDR: eaddr_q <= bus_wdata;
                    OFF_CFG: begin
                        cfg_q <= bus_wdata;
                        if (!cfg_q[DEC_EN_BIT] && bus_wdata[DEC_EN_BIT])
                            stat_q[DEC_EN_BIT] <= 1'b0;
                        else if (cfg_q[DEC_EN_BIT] && !bus_wdata[DEC_EN_BIT])
                            stat_q[DEC_EN_BIT] <= 1'b1;
                        if (!cfg_q[AUX_BIT] && bus_wdata[AUX_BIT])
                            stat_q[AUX_BIT] <= 1'b1;
                        else if (cfg_q[AUX_BIT] && !bus_wdata[AUX_BIT])
                            stat_q[AUX_BIT] <= 1'b0;
                    end
                    OFF_RFSH: rfsh_q <= bus_wdata & MSK_RFSH;
                    OFF_PWR:  pwr_q  <= (bus_wdata & MSK_PWR) | FIX_PWR;
                    OFF_TIM:  tim_q  <= bus_wdata & MSK_TIM;
                    OFF_ECFG: ecfg_q <= bus_wdata & MSK_ECFG;
                    OFF_ESTAT: begin
                        estat_q <= bus_wdata;
                        if (estat_q == '0 && bus_wdata != '0)      irq_q <= 1'b1;
                        else if (estat_q != '0 && bus_wdata == '0) irq_q <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst)                            bank_q[i] <= '0;
            else if (dwr && off_q == bank_off(i)) bank_q[i] <= bus_wdata & MSK_BANK;
        end
        assign maps[i] = unpack_bank(bank_q[i]);
    end

    always_comb begin
        bus_rdata = '0;
        if (!bus_sel) begin
            bus_rdata = {{(DW-OFF_W){1'b0}}, off_q};
        end else begin
            case (off_q)
                OFF_ERR0:  bus_rdata = err0_q;
                OFF_ERR1:  bus_rdata = err1_q;
                OFF_EADDR: bus_rdata = eaddr_q;
                OFF_CFG:   bus_rdata = cfg_q;
                OFF_STAT:  bus_rdata = stat_q;
                OFF_RFSH:  bus_rdata = rfsh_q;
                OFF_PWR:   bus_rdata = pwr_q;
                OFF_TIM:   bus_rdata = tim_q;
                OFF_ECFG:  bus_rdata = ecfg_q;
                OFF_ESTAT: bus_rdata = estat_q;
                default: begin
                    for (int i = 0; i < NUM_BANKS; i++)
                        if (off_q == bank_off(i)) bus_rdata = bank_q[i];
                end
            endcase
        end
    end

    assign dec_en  = cfg_q[DEC_EN_BIT];
    assign ecc_irq = irq_q;

    AST_STAT_IGNORES_WR: assert property (@(posedge clk) disable iff (rst)
        (dwr && off_q != OFF_CFG) |=> $stable(stat_q)); // R4
    AST_DEC_ON_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_q[DEC_EN_BIT]) |-> !stat_q[DEC_EN_BIT]); // R3
    AST_DEC_OFF_SETS: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_q[DEC_EN_BIT]) |-> stat_q[DEC_EN_BIT]); // R3
    AST_PWR_FIXED_ONES: assert property (@(posedge clk) disable iff (rst)
        pwr_q[26:22] == 5'h1F); // R6
    AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
        irq_q == (estat_q != '0)); // R10
    AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (err0_set != '0) |=> ((err0_q & $past(err0_set)) == $past(err0_set))); // R5
endmodule

// File: rtl/mcfg_bank_decode.sv
module mcfg_bank_decode
    import mcfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             dec_en,
    input  bank_map_t        maps [NUM_BANKS],
    input  logic [DW-1:0]    phys_addr,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    logic [NUM_BANKS-1:0] match;

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_cmp
        logic [DW:0] lo, hi;
        assign lo = {1'b0, maps[i].base, 23'b0};
        assign hi = lo + (UNIT_SIZE << maps[i].code);
        assign match[i] = dec_en && maps[i].en && (maps[i].code != 3'd7)
                        && ({1'b0, phys_addr} >= lo) && ({1'b0, phys_addr} < hi);
    end

    always_comb begin
        idx = '0;
        for (int i = NUM_BANKS - 1; i >= 0; i--)
            if (match[i]) idx = IDX_W'(i);
    end
    assign hit = |match;

    AST_HIT_NEEDS_DEC_EN: assert property (@(posedge clk) disable iff (rst)
        hit |-> dec_en); // R8
    AST_WINNER_ENABLED: assert property (@(posedge clk) disable iff (rst)
        hit |-> maps[idx].en); // R9
endmodule

// File: rtl/mcfg_top.sv
module mcfg_top
    import mcfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [31:0]      err0_set,
    input  logic [31:0]      err1_set,
    input  logic [31:0]      phys_addr,
    output logic             bank_hit,
    output logic [1:0]       bank_idx,
    output logic             ecc_irq
);
    logic      dec_en;
    bank_map_t maps [NUM_BANKS];

    mcfg_regfile u_regs (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .err0_set(err0_set), .err1_set(err1_set),
        .dec_en(dec_en), .maps(maps), .ecc_irq(ecc_irq)
    );

    mcfg_bank_decode u_dec (
        .clk(clk), .rst(rst), .dec_en(dec_en), .maps(maps),
        .phys_addr(phys_addr), .hit(bank_hit), .idx(bank_idx)
    );

    AST_NO_HIT_IN_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !bank_hit); // R2
endmodule

// File: tb/mcfg_top_tb_top.sv
module mcfg_top_tb_top;
    logic clk = 0, rst = 1;
    logic bus_sel = 0, bus_wr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic [31:0] err0_set = 0, err1_set = 0, phys_addr = 0;
    logic bank_hit, ecc_irq;
    logic [1:0] bank_idx;
    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    mcfg_top dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .err0_set(err0_set), .err1_set(err1_set), .phys_addr(phys_addr),
        .bank_hit(bank_hit), .bank_idx(bank_idx), .ecc_irq(ecc_irq)
    );

    // bench model
    logic [7:0]  m_off;
    logic [31:0] m_e0, m_e1, m_ea, m_cfg, m_st, m_rf, m_pw, m_tm, m_ec, m_es;
    logic [31:0] m_bank [4];
    logic        m_irq;

    task automatic m_reset();
        m_off = 0; m_e0 = 0; m_e1 = 0; m_ea = 0; m_cfg = 32'h0080_0000; m_st = 0;
        m_rf = 32'h05F0_0000; m_pw = 32'h07C0_0000; m_tm = 32'h0085_4009;
        m_ec = 0; m_es = 0; m_irq = 0;
        for (int i = 0; i < 4; i++) m_bank[i] = 0;
    endtask

    function automatic logic [31:0] m_read(input logic [7:0] o);
        case (o)
            8'h00: return m_e0;  8'h08: return m_e1;  8'h10: return m_ea;
            8'h20: return m_cfg; 8'h24: return m_st;  8'h30: return m_rf;
            8'h34: return m_pw;  8'h80: return m_tm;  8'h94: return m_ec;
            8'h98: return m_es;
            8'h40: return m_bank[0]; 8'h44: return m_bank[1];
            8'h48: return m_bank[2]; 8'h4C: return m_bank[3];
            default: return 0;
        endcase
    endfunction

    task automatic m_write(input logic [7:0] o, input logic [31:0] v);
        case (o)
            8'h00: m_e0 = m_e0 & ~v;
            8'h08: m_e1 = m_e1 & ~v;
            8'h10: m_ea = v;
            8'h20: begin
                if (!m_cfg[31] && v[31]) m_st[31] = 0;
                if (m_cfg[31] && !v[31]) m_st[31] = 1;
                if (!m_cfg[30] && v[30]) m_st[30] = 1;
                if (m_cfg[30] && !v[30]) m_st[30] = 0;
                m_cfg = v;
            end
            8'h30: m_rf = v & 32'h3FF8_0000;
            8'h34: m_pw = (v & 32'hF800_0000) | 32'h07C0_0000;
            8'h80: m_tm = v & 32'h018F_C01F;
            8'h94: m_ec = v & 32'h00F0_0000;
            8'h98: begin m_irq = (v != 0); m_es = v; end
            8'h40: m_bank[0] = v & 32'hFFDE_E001;
            8'h44: m_bank[1] = v & 32'hFFDE_E001;
            8'h48: m_bank[2] = v & 32'hFFDE_E001;
            8'h4C: m_bank[3] = v & 32'hFFDE_E001;
            default: ;
        endcase
    endtask

    function automatic logic [2:0] m_decode(input logic [31:0] a);
        for (int i = 0; i < 4; i++) begin
            logic [32:0] lo, hi;
            lo = {1'b0, m_bank[i][31:23], 23'b0};
            hi = lo + (33'h40_0000 << m_bank[i][19:17]);
            if (m_cfg[31] && m_bank[i][0] && m_bank[i][19:17] != 7 &&
                {1'b0, a} >= lo && {1'b0, a} < hi)
                return {1'b1, 2'(i)};
        end
        return 3'b000;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic wr_off(input logic [7:0] o);
        @(negedge clk); bus_sel = 0; bus_wr = 1; bus_wdata = {24'b0, o};
        @(negedge clk); bus_wr = 0; m_off = o;
    endtask

    task automatic wr_reg(input logic [7:0] o, input logic [31:0] v);
        wr_off(o);
        @(negedge clk); bus_sel = 1; bus_wr = 1; bus_wdata = v;
        @(negedge clk); bus_wr = 0; m_write(o, v);
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] o);
        wr_off(o);
        bus_sel = 1; #1;
        chk(tag, bus_rdata, m_read(o));
    endtask

    task automatic dec_chk(input string tag, input logic [31:0] a);
        logic [2:0] e;
        phys_addr = a; #1;
        e = m_decode(a);
        chk(tag, {29'b0, bank_hit, bank_idx}, {29'b0, e});
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_up();
    end

    localparam logic [7:0] OFFS [16] = '{8'h00, 8'h08, 8'h10, 8'h20, 8'h24, 8'h30,
        8'h34, 8'h40, 8'h44, 8'h48, 8'h4C, 8'h80, 8'h94, 8'h98, 8'h04, 8'h41};

    initial begin
        void'($urandom(32'd1234));
        m_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R2 reset values
        for (int k = 0; k < 16; k++) rd_chk("R2 reset value", OFFS[k]);
        chk("R2 irq after reset", {31'b0, ecc_irq}, 0);
        dec_chk("R2 no hit after reset", 32'h0);
        // R1 address port read back, error address
        wr_off(8'h5A); bus_sel = 0; #1;
        chk("R1 offset readback", bus_rdata, 32'h5A);
        wr_reg(8'h10, 32'hDEAD_BEEF); rd_chk("R1 error address", 8'h10);
        // R4 status ignores writes
        wr_reg(8'h24, 32'hFFFF_FFFF); rd_chk("R4 status write ignored", 8'h24);
        // R3/R4 config transitions
        wr_reg(8'h20, 32'h8000_0000); rd_chk("R3 enable clears status", 8'h24);
        wr_reg(8'h20, 32'h0000_0000); rd_chk("R3 disable sets status", 8'h24);
        chk("R3 status bit31 set", m_st, 32'h8000_0000);
        wr_reg(8'h20, 32'hC000_0000); rd_chk("R4 aux rise", 8'h24);
        chk("R4 status expect", m_st, 32'h4000_0000);
        wr_reg(8'h20, 32'h8000_0000); rd_chk("R4 aux fall", 8'h24);
        // R7/R8/R9 bank decode
        wr_reg(8'h40, 32'h0000_0003 | (32'd1 << 17)); // bank0 base 0, 8 MiB
        wr_reg(8'h44, 32'h0000_0001);                  // bank1 base 0, 4 MiB overlap
        wr_reg(8'h48, 32'h0180_0001 | (32'd7 << 17)); // bank2 code 7 never hits
        wr_reg(8'h4C, 32'h1000_FFFF);                  // bank3 mask check
        rd_chk("R7 bank mask", 8'h4C);
        dec_chk("R9 lowest bank wins", 32'h0000_0100);
        dec_chk("R8 last byte in bank0", 32'h007F_FFFF);
        dec_chk("R8 just past bank0", 32'h0080_0000);
        dec_chk("R8 code 7 no hit", 32'h0180_0000);
        dec_chk("R8 bank3 base", 32'h1000_0000);
        chk("R9 expect bank3", {29'b0, bank_hit, bank_idx}, 32'h7);
        wr_reg(8'h20, 32'h0);
        dec_chk("R8 decode disabled", 32'h0000_0100);
        chk("R8 disabled no hit", {31'b0, bank_hit}, 0);
        wr_reg(8'h20, 32'h8000_0000);
        // R5 error status set and W1C
        @(negedge clk); err0_set = 32'hF0F0_0000; err1_set = 32'h0000_00FF;
        @(negedge clk); err0_set = 0; err1_set = 0;
        m_e0 |= 32'hF0F0_0000; m_e1 |= 32'h0000_00FF;
        rd_chk("R5 error set", 8'h00); rd_chk("R5 error set", 8'h08);
        wr_reg(8'h00, 32'h3030_0000); rd_chk("R5 W1C", 8'h00);
        chk("R5 W1C value", m_e0, 32'hC0C0_0000);
        wr_off(8'h08);
        @(negedge clk); bus_sel = 1; bus_wr = 1; bus_wdata = 32'hFF; err1_set = 32'h01;
        @(negedge clk); bus_wr = 0; err1_set = 0; m_e1 = 32'h01;
        rd_chk("R5 set wins over clear", 8'h08);
        // R6 masks
        wr_reg(8'h30, 32'hFFFF_FFFF); rd_chk("R6 refresh mask", 8'h30);
        wr_reg(8'h34, 32'h0000_0000); rd_chk("R6 power mgmt", 8'h34);
        wr_reg(8'h80, 32'hFFFF_FFFF); rd_chk("R6 timing mask", 8'h80);
        wr_reg(8'h94, 32'hFFFF_FFFF); rd_chk("R6 ecc cfg mask", 8'h94);
        // R10 interrupt
        wr_reg(8'h98, 32'h10);  chk("R10 irq rises", {31'b0, ecc_irq}, 1);
        wr_reg(8'h98, 32'h20);  chk("R10 irq stays", {31'b0, ecc_irq}, 1);
        wr_reg(8'h98, 32'h0);   chk("R10 irq falls", {31'b0, ecc_irq}, 0);
        // R11 unused offsets
        wr_reg(8'h04, 32'hFFFF_FFFF); rd_chk("R11 unused reads zero", 8'h04);
        wr_reg(8'h41, 32'hFFFF_FFFF); rd_chk("R11 unaligned ignored", 8'h41);
        rd_chk("R11 bank0 untouched", 8'h40);
        // random phase
        for (int n = 0; n < 400; n++) begin
            logic [7:0] o;
            logic [31:0] v, a;
            int b;
            o = OFFS[$urandom_range(0, 15)];
            v = $urandom;
            if (o == 8'h20 && ($urandom_range(0, 3) != 0)) v[31] = 1'b1;
            wr_reg(o, v);
            rd_chk("R1 random readback", o);
            chk("R10 random irq", {31'b0, ecc_irq}, {31'b0, m_irq});
            b = $urandom_range(0, 3);
            a = {m_bank[b][31:23], 23'b0} + ($urandom & 32'h01FF_FFFF);
            dec_chk("R8 random decode", a);
            dec_chk("R9 random decode", $urandom);
        end
        finish_up();
    end
endmodule